// File: doc/BRIEF.md
# I2C Status Flag Controller

This block holds the status byte of an I2C peripheral and keeps it current. Each cycle it takes single-cycle event strobes from the bus engine, plus a CPU write port. The events are: start seen, stop seen, arbitration lost, byte finished, data register written, acknowledge missing, duplicate start suppressed, and received address valid. The bus engine owns the protocol sequencing. This block only decides how each flag is set and cleared.

The status byte carries six flags:

- **Mode (bits 7 and 6).** Master and transmit together select one of four operating modes.
- **Bus busy (bit 5).**
- **Pending interrupt (bit 4).** This flag is active low.
- **Arbitration lost (bit 3).**
- **Own-address match (bit 2).**

Bits 1 and 0 always read as zero. The CPU may write the upper nibble and has no write access to the lower nibble. The interrupt request is the inverse of the pending flag.

Top module: `i2c_stat_ctrl`

## Requirements
- R1: After reset the status reads 8'h10: bit 4 (pending, active low) is 1 and every other bit is 0. The interrupt request is low.
- R2: With `stat_we` high and no event, bits 7..4 take `stat_wdata[7:4]` on the next edge. Bits 3..0 ignore the written value, and bits 1..0 always read 0.
- R3: Bit 7 (master) is 0 after an edge where `ev_stop` or `ev_dup_start` was high.
- R4: After `ev_arb_lost`, bit 7 keeps its value until the next `ev_byte_done`. That edge clears bit 7.
- R5: Bit 6 (transmit) clears on `ev_arb_lost` or `ev_stop`. It also clears on `ev_start` or `ev_nack` while bit 7 is 0, and is kept on those two events while bit 7 is 1.
- R6: Bit 5 (bus busy) sets on `ev_start` and clears on `ev_stop`. Stop wins when both occur in the same cycle.
- R7: Bit 4 clears on `ev_byte_done` and sets on `dat_wr`. `ev_byte_done` wins when both occur in the same cycle.
- R8: `irq` equals the inverse of status bit 4 at all times.
- R9: Bit 3 (arbitration lost) sets on `ev_arb_lost` and clears on `ev_start`.
- R10: On `addr_vld`, bit 2 takes 1 if `rx_addr` equals `own_addr`, otherwise 0. With the default configuration `ev_stop` clears it.
- R11: When a hardware event and a CPU status write act on the same bit in one cycle, the hardware event decides the bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| stat_we | input | 1 | CPU write strobe for the status byte |
| stat_wdata | input | 8 | CPU write data |
| dat_wr | input | 1 | CPU wrote the data shift register |
| ev_start | input | 1 | Start condition detected |
| ev_stop | input | 1 | Stop condition detected |
| ev_arb_lost | input | 1 | Arbitration loss detected |
| ev_byte_done | input | 1 | Byte transfer finished |
| ev_nack | input | 1 | Acknowledge not returned |
| ev_dup_start | input | 1 | Start suppressed as duplicate |
| addr_vld | input | 1 | Received address is valid this cycle |
| rx_addr | input | ADDR_W | Received slave address |
| own_addr | input | ADDR_W | Programmed own slave address |
| stat_rdata | output | 8 | Status byte |
| irq | output | 1 | Interrupt request, active high |

## Verification
A CPU status write can land in the same cycle as a bus event that clears the bit being written. The bench provokes this by asserting the write strobe together with a stop, an acknowledge-missing strobe or a suppressed start, and expects the bus event to win. It also pairs a start with a stop and a data register write with a byte completion. In each case the bench compares the status byte one edge later with the value the requirements' priority order gives.

// File: rtl/i2c_stat_pkg.sv
package i2c_stat_pkg;
   localparam int STAT_W  = 8;
   localparam int B_MST   = 7;
   localparam int B_TRX   = 6;
   localparam int B_BB    = 5;
   localparam int B_PIN_N = 4;
   localparam int B_AL    = 3;
   localparam int B_AAS   = 2;
   localparam int SW_LSB  = 4;

   typedef struct packed {
      logic start;
      logic stop;
      logic arb_lost;
      logic byte_done;
      logic nack;
      logic dup_start;
   } bus_ev_t;
endpackage

// File: rtl/i2c_stat_mode.sv
module i2c_stat_mode
   import i2c_stat_pkg::*;
(
   input  logic    clk,
   input  logic    rst_n,
   input  logic    wr_en,
   input  logic    wr_mst,
   input  logic    wr_trx,
   input  bus_ev_t ev,
   output logic    mst,
   output logic    trx
);
   logic arb_pend;
   logic mst_clr, trx_clr;

   // master drops at once on stop or suppressed start; after a lost
   // arbitration it waits for the byte in flight to finish
   assign mst_clr = ev.stop | ev.dup_start | (ev.byte_done & (arb_pend | ev.arb_lost));
   assign trx_clr = ev.arb_lost | ev.stop | (~mst & (ev.start | ev.nack));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         arb_pend <= 1'b0;
      end else if (ev.byte_done || ev.stop) begin
         arb_pend <= 1'b0;
      end else if (ev.arb_lost) begin
         arb_pend <= 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mst <= 1'b0;
      end else if (mst_clr) begin
         mst <= 1'b0;
      end else if (wr_en) begin
         mst <= wr_mst;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         trx <= 1'b0;
      end else if (trx_clr) begin
         trx <= 1'b0;
      end else if (wr_en) begin
         trx <= wr_trx;
      end
   end
endmodule

// File: rtl/i2c_stat_bus.sv
module i2c_stat_bus
   import i2c_stat_pkg::*;
(
   input  logic    clk,
   input  logic    rst_n,
   input  logic    wr_en,
   input  logic    wr_bb,
   input  logic    wr_pin_n,
   input  logic    dat_wr,
   input  bus_ev_t ev,
   output logic    bb,
   output logic    pin_n
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bb <= 1'b0;
      end else if (ev.stop) begin
         bb <= 1'b0;
      end else if (ev.start) begin
         bb <= 1'b1;
      end else if (wr_en) begin
         bb <= wr_bb;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pin_n <= 1'b1;
      end else if (ev.byte_done) begin
         pin_n <= 1'b0;
      end else if (dat_wr) begin
         pin_n <= 1'b1;
      end else if (wr_en) begin
         pin_n <= wr_pin_n;
      end
   end
endmodule

// File: rtl/i2c_stat_flags.sv
module i2c_stat_flags
   import i2c_stat_pkg::*;
#(
   parameter int ADDR_W            = 7,
   parameter bit MATCH_CLR_ON_STOP = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  bus_ev_t           ev,
   input  logic              addr_vld,
   input  logic [ADDR_W-1:0] rx_addr,
   input  logic [ADDR_W-1:0] own_addr,
   output logic              al,
   output logic              aas
);
   logic hit;
   logic aas_clr;

   assign hit = (rx_addr == own_addr);

   generate
      if (MATCH_CLR_ON_STOP) begin : g_clr_stop
         assign aas_clr = ev.stop;
      end else begin : g_keep
         assign aas_clr = 1'b0;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         al <= 1'b0;
      end else if (ev.arb_lost) begin
         al <= 1'b1;
      end else if (ev.start) begin
         al <= 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         aas <= 1'b0;
      end else if (aas_clr) begin
         aas <= 1'b0;
      end else if (addr_vld) begin
         aas <= hit;
      end
   end
endmodule

// File: rtl/i2c_stat_ctrl.sv
module i2c_stat_ctrl
   import i2c_stat_pkg::*;
#(
   parameter int ADDR_W            = 7,
   parameter bit MATCH_CLR_ON_STOP = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              stat_we,
   input  logic [7:0]        stat_wdata,
   input  logic              dat_wr,
   input  logic              ev_start,
   input  logic              ev_stop,
   input  logic              ev_arb_lost,
   input  logic              ev_byte_done,
   input  logic              ev_nack,
   input  logic              ev_dup_start,
   input  logic              addr_vld,
   input  logic [ADDR_W-1:0] rx_addr,
   input  logic [ADDR_W-1:0] own_addr,
   output logic [7:0]        stat_rdata,
   output logic              irq
);
   localparam int RO_W = SW_LSB;

   generate
      if (ADDR_W < 1 || ADDR_W > 10) begin : g_bad_addr_w
         $error("i2c_stat_ctrl: ADDR_W out of range");
      end
      if (STAT_W != 8 || RO_W != 4) begin : g_bad_layout
         $error("i2c_stat_ctrl: status layout mismatch");
      end
   endgenerate

   bus_ev_t ev;
   logic    mst, trx, bb, pin_n, al, aas;

   assign ev = '{start:     ev_start,
                 stop:      ev_stop,
                 arb_lost:  ev_arb_lost,
                 byte_done: ev_byte_done,
                 nack:      ev_nack,
                 dup_start: ev_dup_start};

   i2c_stat_mode u_mode (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_en  (stat_we),
      .wr_mst (stat_wdata[B_MST]),
      .wr_trx (stat_wdata[B_TRX]),
      .ev     (ev),
      .mst    (mst),
      .trx    (trx)
   );

   i2c_stat_bus u_bus (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (stat_we),
      .wr_bb    (stat_wdata[B_BB]),
      .wr_pin_n (stat_wdata[B_PIN_N]),
      .dat_wr   (dat_wr),
      .ev       (ev),
      .bb       (bb),
      .pin_n    (pin_n)
   );

   i2c_stat_flags #(
      .ADDR_W            (ADDR_W),
      .MATCH_CLR_ON_STOP (MATCH_CLR_ON_STOP)
   ) u_flags (
      .clk      (clk),
      .rst_n    (rst_n),
      .ev       (ev),
      .addr_vld (addr_vld),
      .rx_addr  (rx_addr),
      .own_addr (own_addr),
      .al       (al),
      .aas      (aas)
   );

   always_comb begin
      stat_rdata          = '0;
      stat_rdata[B_MST]   = mst;
      stat_rdata[B_TRX]   = trx;
      stat_rdata[B_BB]    = bb;
      stat_rdata[B_PIN_N] = pin_n;
      stat_rdata[B_AL]    = al;
      stat_rdata[B_AAS]   = aas;
   end

   assign irq = ~pin_n;
endmodule

// File: rtl/i2c_stat_ctrl_chk.sv
module i2c_stat_ctrl_chk #(
   parameter int ADDR_W = 7
) (
   input logic              clk,
   input logic              rst_n,
   input logic              stat_we,
   input logic              dat_wr,
   input logic              ev_start,
   input logic              ev_stop,
   input logic              ev_arb_lost,
   input logic              ev_byte_done,
   input logic              ev_dup_start,
   input logic              addr_vld,
   input logic [ADDR_W-1:0] rx_addr,
   input logic [ADDR_W-1:0] own_addr,
   input logic [7:0]        stat_rdata,
   input logic              irq
);
   p_low_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
      stat_rdata[1:0] == 2'b00);
   p_stop_mst_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (ev_stop || ev_dup_start) |=> !stat_rdata[7]);
   p_al_hold_mst_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (stat_rdata[7] && ev_arb_lost && !ev_stop && !ev_dup_start && !ev_byte_done && !stat_we)
      |=> stat_rdata[7]);
   p_trx_clr_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (ev_arb_lost || ev_stop) |=> !stat_rdata[6]);
   p_bb_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (ev_start && !ev_stop) |=> stat_rdata[5]);
   p_bb_clr_r6: assert property (@(posedge clk) disable iff (!rst_n)
      ev_stop |=> !stat_rdata[5]);
   p_pin_clr_r7: assert property (@(posedge clk) disable iff (!rst_n)
      ev_byte_done |=> !stat_rdata[4]);
   p_pin_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (dat_wr && !ev_byte_done) |=> stat_rdata[4]);
   p_irq_inv_r8: assert property (@(posedge clk) disable iff (!rst_n)
      irq == !stat_rdata[4]);
   p_al_set_r9: assert property (@(posedge clk) disable iff (!rst_n)
      ev_arb_lost |=> stat_rdata[3]);
   p_match_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (addr_vld && !ev_stop) |=> stat_rdata[2] == $past(rx_addr == own_addr));
endmodule

bind i2c_stat_ctrl i2c_stat_ctrl_chk #(.ADDR_W(ADDR_W)) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .stat_we      (stat_we),
   .dat_wr       (dat_wr),
   .ev_start     (ev_start),
   .ev_stop      (ev_stop),
   .ev_arb_lost  (ev_arb_lost),
   .ev_byte_done (ev_byte_done),
   .ev_dup_start (ev_dup_start),
   .addr_vld     (addr_vld),
   .rx_addr      (rx_addr),
   .own_addr     (own_addr),
   .stat_rdata   (stat_rdata),
   .irq          (irq)
);

// File: tb/i2c_stat_ctrl_bench.sv
module i2c_stat_ctrl_bench;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       stat_we = 1'b0;
   logic [7:0] stat_wdata = '0;
   logic       dat_wr = 1'b0;
   logic       ev_start = 1'b0, ev_stop = 1'b0, ev_arb_lost = 1'b0;
   logic       ev_byte_done = 1'b0, ev_nack = 1'b0, ev_dup_start = 1'b0;
   logic       addr_vld = 1'b0;
   logic [6:0] rx_addr = '0;
   logic [6:0] own_addr = 7'h2A;
   logic [7:0] stat_rdata;
   logic       irq;

   int checks = 0;
   int fails  = 0;

   always #2.5 clk = ~clk;

   i2c_stat_ctrl u_i2c_stat_ctrl (
      .clk(clk), .rst_n(rst_n), .stat_we(stat_we), .stat_wdata(stat_wdata),
      .dat_wr(dat_wr), .ev_start(ev_start), .ev_stop(ev_stop),
      .ev_arb_lost(ev_arb_lost), .ev_byte_done(ev_byte_done), .ev_nack(ev_nack),
      .ev_dup_start(ev_dup_start), .addr_vld(addr_vld), .rx_addr(rx_addr),
      .own_addr(own_addr), .stat_rdata(stat_rdata), .irq(irq)
   );

   typedef struct packed {
      logic       we;
      logic [7:0] wd;
      logic       dw, st, sp, al, bd, nk, dp, av;
      logic [6:0] ra;
      logic [7:0] exp;
   } vec_t;

   // fields: we wd dw st sp al bd nk dp av ra exp
   localparam int NV = 22;
   localparam vec_t VT [NV] = '{
      '{1'b1, 8'hEF, 0,0,0,0,0,0,0,0, 7'h00, 8'hE0}, // R2 write upper only
      '{1'b0, 8'h00, 1,0,0,0,0,0,0,0, 7'h00, 8'hF0}, // R7 data write sets pending
      '{1'b0, 8'h00, 0,0,0,0,1,0,0,0, 7'h00, 8'hE0}, // R7 byte done clears
      '{1'b0, 8'h00, 0,0,0,0,0,1,0,0, 7'h00, 8'hE0}, // R5 nack as master keeps trx
      '{1'b0, 8'h00, 0,1,0,0,0,0,0,0, 7'h00, 8'hE0}, // R5 start as master keeps trx
      '{1'b0, 8'h00, 0,0,0,1,0,0,0,0, 7'h00, 8'hA8}, // R4 R5 R9 arb lost
      '{1'b0, 8'h00, 1,0,0,0,0,0,0,0, 7'h00, 8'hB8}, // R4 master held
      '{1'b0, 8'h00, 0,0,0,0,1,0,0,0, 7'h00, 8'h28}, // R4 byte done drops master
      '{1'b0, 8'h00, 0,1,0,0,0,0,0,0, 7'h00, 8'h20}, // R9 start clears al
      '{1'b0, 8'h00, 0,0,0,0,0,0,0,1, 7'h2A, 8'h24}, // R10 match
      '{1'b0, 8'h00, 0,0,0,0,0,0,0,1, 7'h2B, 8'h20}, // R10 mismatch
      '{1'b1, 8'h50, 0,0,0,0,0,0,0,0, 7'h00, 8'h50}, // R2 slave transmitter
      '{1'b0, 8'h00, 0,1,0,0,0,0,0,0, 7'h00, 8'h30}, // R5 R6 start as slave
      '{1'b1, 8'hF0, 0,0,1,0,0,0,0,0, 7'h00, 8'h10}, // R11 R3 R6 write vs stop
      '{1'b1, 8'h40, 0,0,0,0,0,1,0,0, 7'h00, 8'h00}, // R11 R5 write vs nack
      '{1'b1, 8'h80, 0,0,0,0,0,0,1,0, 7'h00, 8'h00}, // R11 R3 write vs dup start
      '{1'b0, 8'h00, 0,1,1,0,0,0,0,0, 7'h00, 8'h00}, // R6 stop beats start
      '{1'b0, 8'h00, 0,0,0,0,0,0,0,1, 7'h2A, 8'h04}, // R10 match again
      '{1'b0, 8'h00, 0,0,1,0,0,0,0,0, 7'h00, 8'h00}, // R10 stop clears match
      '{1'b0, 8'h00, 1,0,0,0,0,0,0,0, 7'h00, 8'h10}, // R7 set pending
      '{1'b0, 8'h00, 1,0,0,0,1,0,0,0, 7'h00, 8'h00}, // R7 byte done wins
      '{1'b1, 8'hAF, 0,0,0,0,0,0,0,0, 7'h00, 8'hA0}  // R2 low nibble ignored
   };

   task automatic check8(input string req, input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic check_irq(input string req, input logic exp_pin);
      checks++;
      if (irq !== ~exp_pin) begin
         fails++;
         $display("FAIL %s irq actual=%b expected=%b", req, irq, ~exp_pin);
      end
   endtask

   initial begin : watchdog
      repeat (5000) @(posedge clk);
      fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin : main
      repeat (3) @(negedge clk);
      check8("R1 reset status", stat_rdata, 8'h10);
      check_irq("R1 R8 reset irq", 1'b1);
      rst_n = 1'b1;
      @(negedge clk);
      for (int i = 0; i < NV; i++) begin
         stat_we = VT[i].we; stat_wdata = VT[i].wd; dat_wr = VT[i].dw;
         ev_start = VT[i].st; ev_stop = VT[i].sp; ev_arb_lost = VT[i].al;
         ev_byte_done = VT[i].bd; ev_nack = VT[i].nk; ev_dup_start = VT[i].dp;
         addr_vld = VT[i].av; rx_addr = VT[i].ra;
         @(negedge clk);
         check8($sformatf("vector %0d", i), stat_rdata, VT[i].exp);
         check_irq($sformatf("R8 vector %0d", i), VT[i].exp[4]);
      end
      stat_we = 1'b0; dat_wr = 1'b0; ev_start = 1'b0; ev_stop = 1'b0;
      ev_arb_lost = 1'b0; ev_byte_done = 1'b0; ev_nack = 1'b0;
      ev_dup_start = 1'b0; addr_vld = 1'b0;
      // R1 reset in mid-run restores reset value
      rst_n = 1'b0;
      @(negedge clk);
      check8("R1 mid-run reset", stat_rdata, 8'h10);
      rst_n = 1'b1;
      @(negedge clk);
      // R4 arb pending dropped by stop: a later byte done leaves master set
      stat_we = 1'b1; stat_wdata = 8'h80;
      @(negedge clk);
      stat_we = 1'b0; ev_arb_lost = 1'b1;
      @(negedge clk);
      ev_arb_lost = 1'b0; ev_stop = 1'b1;
      @(negedge clk);
      ev_stop = 1'b0; stat_we = 1'b1; stat_wdata = 8'h80;
      @(negedge clk);
      stat_we = 1'b0; ev_byte_done = 1'b1;
      @(negedge clk);
      ev_byte_done = 1'b0;
      check8("R4 pending cleared by stop", stat_rdata, 8'h88);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule